// File: doc/BRIEF.md
# Floating-Point Compare to Mask Unit

This block compares single-precision floating-point operands across N parallel lanes and produces one mask bit per lane in the same cycle. Each lane compares an element of vector operand A against the matching element of vector operand B, or against one scalar value broadcast to every lane. Six relations are supported: equal, not-equal, less-than, less-or-equal, greater-than and greater-or-equal. The result mask can drive a downstream mask port directly, with no register in between.

Lanes that are switched off by the active-lane mask pass the previous destination mask bit through unchanged. The five-bit exception flag output is the OR of the per-lane flags over active lanes only. Equality relations are quiet and raise invalid only on a signaling NaN. Ordering relations are signaling and raise invalid on any NaN. A caller can therefore make an ordering compare quiet by first limiting the active mask to lanes whose operands are not NaN.

Top module: `fcmp_mask_unit`

## Requirements
- R1: With `cmp_sel` = 0 (equal), an active lane writes 1 exactly when neither operand is NaN and the values are equal. +0.0 and -0.0 are equal.
- R2: With `cmp_sel` = 1 (not-equal), an active lane writes the inverse of the equal result, so it writes 1 whenever either operand is NaN.
- R3: With `cmp_sel` = 2 (A < B) or 3 (A <= B), an active lane writes the IEEE ordering result. It writes 0 when either operand is NaN. Signed zeros are equal.
- R4: With `cmp_sel` = 4 (A > scalar) or 5 (A >= scalar), the relation is evaluated only when `use_scalar` = 1. With `use_scalar` = 0, or with `cmp_sel` = 6 or 7, no compare takes place: `mask_out` equals `old_mask` and `fflags` is 0.
- R5: When `use_scalar` = 1, every lane takes `scalar_b` as its B operand in place of its slice of `b_vec`. This holds for every relation.
- R6: A lane whose `lane_en` bit is 0 drives `old_mask` for that lane onto `mask_out`.
- R7: For equal and not-equal, an active lane raises invalid only when an operand is a signaling NaN. A NaN has an all-ones exponent (bits 30:23) and a nonzero fraction. It is signaling when fraction bit 22 is 0.
- R8: For the four ordering relations, an active lane raises invalid when either operand is any NaN, quiet or signaling.
- R9: `fflags` bit 4 is the OR of invalid over active lanes only. Bits 3:0 are always 0. With no active lane, `fflags` is 0.
- R10: `mask_out` and `fflags` are pure combinational functions of the current inputs and settle within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_vec | input | N_LANES*32 | Operand A. Lane i occupies bits 32i+31:32i. |
| b_vec | input | N_LANES*32 | Operand B, per lane. |
| scalar_b | input | 32 | Scalar B operand, broadcast to all lanes. |
| use_scalar | input | 1 | 1 selects `scalar_b` as the B operand of every lane. |
| cmp_sel | input | 3 | Relation: 0 eq, 1 ne, 2 lt, 3 le, 4 gt, 5 ge. |
| lane_en | input | N_LANES | Active-lane mask. |
| old_mask | input | N_LANES | Prior destination mask bits, kept in inactive lanes. |
| mask_out | output | N_LANES | Result mask. |
| fflags | output | 5 | Exception flags. Bit 4 is invalid; bits 3:0 are 0. |

## Verification
The block has no state, so any fault in a lane's classification or relation logic appears on `mask_out` or `fflags` in the same cycle as the offending operands. A misread NaN class shows up as a flag that appears under an equality compare, or that is missing under an ordering compare. A lane-select fault shows up as a masked-off lane that leaks its result or its flag. The stimulus deliberately mixes signed zeros, infinities, quiet NaNs, signaling NaNs and repeated operands, so that each of these faults is exposed on the vector that triggers it.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

   localparam logic [2:0] OP_EQ = 3'd0;
   localparam logic [2:0] OP_NE = 3'd1;
   localparam logic [2:0] OP_LT = 3'd2;
   localparam logic [2:0] OP_LE = 3'd3;
   localparam logic [2:0] OP_GT = 3'd4;
   localparam logic [2:0] OP_GE = 3'd5;

   localparam int FLAG_W   = 5;
   localparam int FLAG_INV = 4;

   typedef struct packed {
      logic is_nan;
      logic is_snan;
      logic is_zero;
      logic sign;
   } fclass_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
   import fcmp_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W = EXP_W + MAN_W + 1
) (
   input  logic [W-1:0] x_i,
   output fclass_t      cls_o
);

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;

   assign exp_f = x_i[W-2:MAN_W];
   assign man_f = x_i[MAN_W-1:0];

   always_comb begin
      cls_o.sign    = x_i[W-1];
      cls_o.is_zero = (x_i[W-2:0] == '0);
      cls_o.is_nan  = (&exp_f) && (|man_f);
      cls_o.is_snan = (&exp_f) && (|man_f) && !man_f[MAN_W-1];
   end

endmodule

// File: rtl/fcmp_lane.sv
module fcmp_lane
   import fcmp_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W = EXP_W + MAN_W + 1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [2:0]   op_i,
   input  logic         legal_i,
   input  logic         en_i,
   input  logic         old_i,
   output logic         bit_o,
   output logic         inv_o
);

   fclass_t ca, cb;
   logic    any_nan, any_snan, both_zero;
   logic    eq_r, lt_ab, lt_ba, rel;
   logic [W-2:0] mag_a, mag_b;

   fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (.x_i(a_i), .cls_o(ca));
   fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (.x_i(b_i), .cls_o(cb));

   assign mag_a     = a_i[W-2:0];
   assign mag_b     = b_i[W-2:0];
   assign any_nan   = ca.is_nan | cb.is_nan;
   assign any_snan  = ca.is_snan | cb.is_snan;
   assign both_zero = ca.is_zero & cb.is_zero;

   // Ordering on sign-magnitude: negative below positive, magnitude reversed when negative.
   always_comb begin
      eq_r  = !any_nan && ((a_i == b_i) || both_zero);
      lt_ab = 1'b0;
      lt_ba = 1'b0;
      if (!any_nan && !both_zero) begin
         if (ca.sign != cb.sign) begin
            lt_ab = ca.sign;
            lt_ba = cb.sign;
         end else if (!ca.sign) begin
            lt_ab = mag_a < mag_b;
            lt_ba = mag_b < mag_a;
         end else begin
            lt_ab = mag_a > mag_b;
            lt_ba = mag_b > mag_a;
         end
      end
   end

   always_comb begin
      unique case (op_i)
         OP_EQ:   rel = eq_r;
         OP_NE:   rel = !eq_r;
         OP_LT:   rel = lt_ab;
         OP_LE:   rel = lt_ab | eq_r;
         OP_GT:   rel = lt_ba;
         OP_GE:   rel = lt_ba | eq_r;
         default: rel = 1'b0;
      endcase
   end

   always_comb begin
      bit_o = old_i;
      inv_o = 1'b0;
      if (en_i && legal_i) begin
         bit_o = rel;
         inv_o = (op_i == OP_EQ || op_i == OP_NE) ? any_snan : any_nan;
      end
   end

   always_comb begin
      // NaN makes every relation except not-equal false (R1, R3)
      if (en_i && legal_i && op_i != OP_NE && any_nan)
         assert_nan_false_R3: assert (bit_o == 1'b0) else $error("NaN gave a true relation");
      if (en_i && legal_i && op_i == OP_NE && any_nan)
         assert_ne_nan_set_R2: assert (bit_o == 1'b1) else $error("ne on NaN not set");
      if (en_i && legal_i && op_i == OP_EQ && both_zero)
         assert_zero_equal_R1: assert (bit_o == 1'b1) else $error("signed zeros unequal");
      assert_order_excl_R3: assert (!(lt_ab && lt_ba) && !(eq_r && lt_ab))
         else $error("ordering relations overlap");
   end

endmodule

// File: rtl/fcmp_flag_reduce.sv
module fcmp_flag_reduce
   import fcmp_pkg::*;
#(
   parameter int N_LANES = 4
) (
   input  logic [N_LANES-1:0] inv_i,
   input  logic [N_LANES-1:0] en_i,
   output logic [FLAG_W-1:0]  flags_o
);

   logic inv_any;

   generate
      if (N_LANES == 1) begin : g_single
         assign inv_any = inv_i[0];
      end else begin : g_multi
         assign inv_any = |inv_i;
      end
   endgenerate

   always_comb begin
      flags_o = '0;
      flags_o[FLAG_INV] = inv_any;
   end

   always_comb begin
      // flags from switched-off lanes never reach the output (R9)
      if (en_i == '0)
         assert_idle_quiet_R9: assert (flags_o == '0) else $error("flag with no active lane");
   end

endmodule

// File: rtl/fcmp_mask_unit.sv
module fcmp_mask_unit
   import fcmp_pkg::*;
#(
   parameter int N_LANES = 4,
   parameter int EXP_W   = 8,
   parameter int MAN_W   = 23,
   localparam int W      = EXP_W + MAN_W + 1,
   localparam int VEC_W  = N_LANES * W
) (
   input  logic [VEC_W-1:0]   a_vec,
   input  logic [VEC_W-1:0]   b_vec,
   input  logic [W-1:0]       scalar_b,
   input  logic               use_scalar,
   input  logic [2:0]         cmp_sel,
   input  logic [N_LANES-1:0] lane_en,
   input  logic [N_LANES-1:0] old_mask,
   output logic [N_LANES-1:0] mask_out,
   output logic [FLAG_W-1:0]  fflags
);

   generate
      if (N_LANES < 1 || EXP_W < 2 || MAN_W < 2) begin : g_bad_param
         $error("fcmp_mask_unit: parameter out of range");
      end
   endgenerate

   logic               legal;
   logic [N_LANES-1:0] inv_lane;

   // gt/ge exist only against the scalar; codes 6 and 7 are unused
   assign legal = (cmp_sel <= OP_GE) && !((cmp_sel >= OP_GT) && !use_scalar);

   generate
      for (genvar i = 0; i < N_LANES; i++) begin : g_lane
         logic [W-1:0] b_sel;
         assign b_sel = use_scalar ? scalar_b : b_vec[i*W +: W];
         fcmp_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_lane (
            .a_i     (a_vec[i*W +: W]),
            .b_i     (b_sel),
            .op_i    (cmp_sel),
            .legal_i (legal),
            .en_i    (lane_en[i]),
            .old_i   (old_mask[i]),
            .bit_o   (mask_out[i]),
            .inv_o   (inv_lane[i])
         );
      end
   endgenerate

   fcmp_flag_reduce #(.N_LANES(N_LANES)) u_flags (
      .inv_i   (inv_lane),
      .en_i    (lane_en),
      .flags_o (fflags)
   );

   always_comb begin
      if (!legal)
         assert_illegal_hold_R4: assert (mask_out == old_mask && fflags == '0)
            else $error("illegal op changed outputs");
   end

endmodule

// File: tb/sim_fcmp_mask_unit.sv
module sim_fcmp_mask_unit;
   localparam int N = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [N*32-1:0] a_vec, b_vec;
   logic [31:0]     scalar_b;
   logic            use_scalar;
   logic [2:0]      cmp_sel;
   logic [N-1:0]    lane_en, old_mask, mask_out;
   logic [4:0]      fflags;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   fcmp_mask_unit #(.N_LANES(N)) u0 (
      .a_vec(a_vec), .b_vec(b_vec), .scalar_b(scalar_b), .use_scalar(use_scalar),
      .cmp_sel(cmp_sel), .lane_en(lane_en), .old_mask(old_mask),
      .mask_out(mask_out), .fflags(fflags)
   );

   function automatic bit is_nan(logic [31:0] x);
      return (x[30:23] == 8'hFF) && (x[22:0] != 0);
   endfunction
   function automatic bit is_snan(logic [31:0] x);
      return is_nan(x) && !x[22];
   endfunction
   // monotone integer key; -0 folds onto +0
   function automatic logic [31:0] okey(logic [31:0] x);
      if (x[30:0] == 0) return 32'h8000_0000;
      return x[31] ? ~x : (x | 32'h8000_0000);
   endfunction
   function automatic bit op_legal(logic [2:0] op, logic sc);
      if (op > 3'd5) return 0;
      if (op >= 3'd4 && !sc) return 0;
      return 1;
   endfunction
   function automatic bit ref_rel(logic [31:0] a, logic [31:0] b, logic [2:0] op);
      bit nan = is_nan(a) || is_nan(b);
      case (op)
         3'd0: return !nan && okey(a) == okey(b);
         3'd1: return nan || okey(a) != okey(b);
         3'd2: return !nan && okey(a) <  okey(b);
         3'd3: return !nan && okey(a) <= okey(b);
         3'd4: return !nan && okey(a) >  okey(b);
         3'd5: return !nan && okey(a) >= okey(b);
         default: return 0;
      endcase
   endfunction
   function automatic string op_tag(logic [2:0] op, logic sc);
      if (!op_legal(op, sc)) return "R4";
      case (op)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2, 3'd3: return "R3";
         default: return "R4";
      endcase
   endfunction

   function automatic logic [31:0] pick(logic [31:0] other);
      case ($urandom % 10)
         0: return 32'h0000_0000;
         1: return 32'h8000_0000;
         2: return {$urandom % 2 == 0 ? 1'b0 : 1'b1, 31'h7F80_0000};
         3: return {1'b0, 8'hFF, 1'b1, 22'($urandom)};
         4: return {1'b1, 8'hFF, 1'b0, 21'($urandom), 1'b1};
         5: return other;
         6: return {other[31:1], ~other[0]};
         7: return {~other[31], other[30:0]};
         default: return $urandom;
      endcase
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   // drive after the falling edge; sample 1 ns later, same cycle (R10)
   task automatic run_vec(string tag);
      logic [N-1:0] em;
      logic [4:0]   ef;
      @(negedge clk);
      em = old_mask;
      ef = 0;
      for (int i = 0; i < N; i++) begin
         logic [31:0] a, b;
         a = a_vec[i*32 +: 32];
         b = use_scalar ? scalar_b : b_vec[i*32 +: 32];
         if (lane_en[i] && op_legal(cmp_sel, use_scalar)) begin
            em[i] = ref_rel(a, b, cmp_sel);
            if (cmp_sel <= 3'd1) ef[4] = ef[4] | is_snan(a) | is_snan(b);
            else                 ef[4] = ef[4] | is_nan(a)  | is_nan(b);
         end
      end
      #1;
      check({tag, "/", op_tag(cmp_sel, use_scalar)}, "mask", 32'(mask_out), 32'(em));
      check({tag, cmp_sel <= 3'd1 ? "/R7" : "/R8", "/R9"}, "flags", 32'(fflags), 32'(ef));
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      a_vec = 0; b_vec = 0; scalar_b = 0; use_scalar = 0;
      cmp_sel = 0; lane_en = 0; old_mask = 4'b1010;
      // reset-like state: nothing active, old mask passes (R6, R9)
      run_vec("idle_R6");

      // R1: signed zeros equal in every lane
      a_vec = {4{32'h8000_0000}}; b_vec = {4{32'h0000_0000}};
      lane_en = 4'hF; cmp_sel = 3'd0;
      run_vec("zero_R1");
      check("R1", "zero eq mask", 32'(mask_out), 32'hF);

      // R2/R7: quiet NaN under ne sets 1, raises nothing
      a_vec = {4{32'h7FC0_0000}}; b_vec = {4{32'h3F80_0000}}; cmp_sel = 3'd1;
      run_vec("qnan_ne_R2");
      check("R7", "quiet ne flags", 32'(fflags), 32'h0);

      // R8: quiet NaN under lt raises invalid
      cmp_sel = 3'd2;
      run_vec("qnan_lt_R8");
      check("R8", "ordered flags", 32'(fflags), 32'h10);

      // R9: NaN only in masked-off lanes stays quiet
      a_vec = {32'h7FC0_0000, 32'h7FA0_0000, 32'h4000_0000, 32'hC000_0000};
      lane_en = 4'b0011; old_mask = 4'b1100;
      run_vec("masked_R9");
      check("R9", "masked flags", 32'(fflags), 32'h0);

      // R4: gt without scalar form is not performed
      lane_en = 4'hF; old_mask = 4'b0110; cmp_sel = 3'd4; use_scalar = 0;
      run_vec("gt_vv_R4");
      check("R4", "gt.vv hold", 32'(mask_out), 32'h6);

      // R5: scalar broadcast replaces b_vec
      a_vec = {32'h4000_0000, 32'h3F80_0000, 32'hBF80_0000, 32'h4040_0000};
      b_vec = {4{32'hFF80_0000}}; scalar_b = 32'h3F80_0000; use_scalar = 1;
      cmp_sel = 3'd5;
      run_vec("bcast_R5");
      check("R5", "ge scalar", 32'(mask_out), 32'b1101);

      for (int k = 0; k < 3000; k++) begin
         for (int i = 0; i < N; i++) begin
            a_vec[i*32 +: 32] = $urandom;
            a_vec[i*32 +: 32] = pick(a_vec[i*32 +: 32]);
            b_vec[i*32 +: 32] = pick(a_vec[i*32 +: 32]);
         end
         scalar_b   = pick(a_vec[31:0]);
         use_scalar = 1'($urandom);
         cmp_sel    = 3'($urandom);
         lane_en    = 4'($urandom);
         old_mask   = 4'($urandom);
         run_vec("rand");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule